// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Expander

This block takes a wide field of peripheral interrupt inputs, 96 by default, and folds them onto a small set of CPU request lines. The inputs are split into groups of eight, and each group feeds one CPU line. An interrupt passes two latch-and-gate stages on its way to the core. The first is a pending bit and an enable bit for each input, inside its group. The second is a pending bit and an enable bit for each CPU line. A single global mask bit comes after both stages.

Each group also has an acknowledge latch. The latch is set when the group hands a request to its CPU line, and it holds the group back until software releases it. When the core takes an interrupt, the block gives the winning group and input index as a vector. In the same edge it clears the input-level pending bit and the line-level pending bit behind that vector.

Software reaches every pending, enable, acknowledge and mask register through a flat write/read port. Input-level pending registers use write-one-to-set, so software can raise interrupts of its own at any position. A peripheral pulse that lands during such a write is never lost.

Top module: `irq_expander`

## Requirements
- R1: Input bit 8*g+i belongs to group g, input index i. Group g feeds CPU line g. The vector reports vec_grp = g and vec_idx = i.
- R2: A high input in any cycle sets its input pending bit at the next edge, whether or not its input enable bit is set. The bit stays set until the core takes it. It reads back at address g, bit i. The input enable register of group g is at address 12+g.
- R3: When a group has an input that is both pending and enabled, and its acknowledge bit is clear, one edge later the block sets line pending bit g and acknowledge bit g. While acknowledge bit g is set, the group forwards nothing new.
- R4: Writing 1 to bit g at address 24 clears acknowledge bit g. Bits written 0 keep their value. The acknowledge register reads back at address 24.
- R5: The global mask is bit 0 at address 27. While it is 1, cpu_irq stays low. Reset leaves it at 1.
- R6: cpu_irq is high when some line is both pending and line-enabled and the mask is 0. The lowest such line is reported as vec_grp. vec_idx is the lowest input of that group that is both pending and enabled.
- R7: A cpu_take strobe while cpu_irq is high clears line pending bit vec_grp and input pending bit vec_idx of that group in one edge. All other pending bits keep their value.
- R8: Writes to an input pending register set the bits written 1 and leave the bits written 0 unchanged. An input that arrives in the same cycle as such a write is kept. A bit set by software is forwarded the same way as one set by hardware.
- R9: Line pending bits read at address 25, which is also write-one-to-set. Line enable bits are read and written at address 26. A pending line whose enable bit is clear does not raise cpu_irq.
- R10: A synchronous active-low reset clears every pending bit, enable bit and acknowledge bit, and sets the global mask.
- R11: cpu_take while cpu_irq is low changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 96 | Peripheral interrupt inputs, group-major |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data (combinational) |
| cpu_irq | output | 1 | Interrupt request to the core |
| vec_grp | output | 4 | Winning group number |
| vec_idx | output | 3 | Winning input index within the group |
| cpu_take | input | 1 | Core takes the reported interrupt |

## Verification
Two situations are the hardest to reach from the ports. The first is the acknowledge latch blocking a group that has fresh pending work. The bench takes an interrupt, pulses the same input again with the latch still set, and confirms that the line stays quiet until a write-one releases the latch. The second is a peripheral pulse that lands in the very cycle software writes the same pending register. The bench drives the input and the write strobe in one cycle, then reads back the register to see both bits. It also runs several groups at once, with staggered enables, so that the priority order and the single-bit clear on take can be seen as each group is drained in turn.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
    localparam int unsigned IRQX_GROUPS = 12;
    localparam int unsigned IRQX_LINES  = 8;

    // control registers placed after the per-group flag and enable blocks
    typedef enum int unsigned {
        CTL_ACK  = 0,
        CTL_CPUF = 1,
        CTL_CPUE = 2,
        CTL_MASK = 3
    } irqx_ctl_e;
endpackage

// File: rtl/irqx_lsb.sv
module irqx_lsb #(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/irqx_group.sv
module irqx_group #(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  src,
    input  logic          set_wr,
    input  logic          en_wr,
    input  logic [W-1:0]  wdata,
    input  logic          clr,
    input  logic [IW-1:0] clr_idx,
    output logic [W-1:0]  flag,
    output logic [W-1:0]  en,
    output logic          pend,
    output logic [IW-1:0] pend_idx
);
    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] en;
    } grp_st_t;

    grp_st_t st_d, st_q;
    logic [W-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr) clr_mask[clr_idx] = 1'b1;
        st_d = st_q;
        // set sources win over the clear so no arriving pulse is dropped
        st_d.flag = (st_q.flag & ~clr_mask) | src | (set_wr ? wdata : '0);
        if (en_wr) st_d.en = wdata;
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign en   = st_q.en;

    irqx_lsb #(.W(W)) pick_i (
        .vec (st_q.flag & st_q.en),
        .any (pend),
        .idx (pend_idx)
    );
endmodule

// File: rtl/irq_expander.sv
module irq_expander
    import irqx_pkg::*;
#(
    parameter int unsigned NUM_GRP = IRQX_GROUPS,
    parameter int unsigned GRP_W   = IRQX_LINES,
    localparam int unsigned GW     = $clog2(NUM_GRP),
    localparam int unsigned IW     = $clog2(GRP_W),
    localparam int unsigned AW     = $clog2(2 * NUM_GRP + 4),
    localparam int unsigned DATA_W = (NUM_GRP > GRP_W) ? NUM_GRP : GRP_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_GRP*GRP_W-1:0]   irq_in,
    input  logic                       reg_wr,
    input  logic [AW-1:0]              reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic                       cpu_irq,
    output logic [GW-1:0]              vec_grp,
    output logic [IW-1:0]              vec_idx,
    input  logic                       cpu_take
);
    localparam int unsigned EN_BASE = NUM_GRP;
    localparam int unsigned CTL_BASE = 2 * NUM_GRP;
    localparam logic [AW-1:0] A_ACK  = AW'(CTL_BASE + CTL_ACK);
    localparam logic [AW-1:0] A_CPUF = AW'(CTL_BASE + CTL_CPUF);
    localparam logic [AW-1:0] A_CPUE = AW'(CTL_BASE + CTL_CPUE);
    localparam logic [AW-1:0] A_MASK = AW'(CTL_BASE + CTL_MASK);

    typedef struct packed {
        logic [NUM_GRP-1:0] cpu_flag;
        logic [NUM_GRP-1:0] cpu_en;
        logic [NUM_GRP-1:0] ack;
        logic               gmask;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [GRP_W-1:0]   grp_flag [NUM_GRP];
    logic [GRP_W-1:0]   grp_en   [NUM_GRP];
    logic [IW-1:0]      grp_idx  [NUM_GRP];
    logic [NUM_GRP-1:0] grp_pend;
    logic [NUM_GRP-1:0] grp_clr;
    logic [NUM_GRP-1:0] fwd;
    logic               line_any;
    logic [GW-1:0]      line_idx;
    logic               take_ok;

    // per-group input stage
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        irqx_group #(.W(GRP_W)) grp_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (irq_in[g*GRP_W +: GRP_W]),
            .set_wr   (reg_wr && (reg_addr == AW'(g))),
            .en_wr    (reg_wr && (reg_addr == AW'(EN_BASE + g))),
            .wdata    (reg_wdata[GRP_W-1:0]),
            .clr      (grp_clr[g]),
            .clr_idx  (vec_idx),
            .flag     (grp_flag[g]),
            .en       (grp_en[g]),
            .pend     (grp_pend[g]),
            .pend_idx (grp_idx[g])
        );
        assign grp_clr[g] = take_ok && (line_idx == GW'(g));
    end

    // line stage arbitration
    irqx_lsb #(.W(NUM_GRP)) line_pick_i (
        .vec (st_q.cpu_flag & st_q.cpu_en),
        .any (line_any),
        .idx (line_idx)
    );

    assign cpu_irq = line_any && !st_q.gmask;
    assign vec_grp = line_idx;
    assign take_ok = cpu_take && cpu_irq;
    assign fwd     = grp_pend & ~st_q.ack;

    always_comb begin
        vec_idx = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (line_idx == GW'(g)) vec_idx = grp_idx[g];
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.cpu_flag = (st_q.cpu_flag & ~grp_clr) | fwd
                      | ((reg_wr && reg_addr == A_CPUF) ? reg_wdata[NUM_GRP-1:0] : '0);
        st_d.ack      = (st_q.ack & ~((reg_wr && reg_addr == A_ACK) ? reg_wdata[NUM_GRP-1:0] : '0))
                      | fwd;
        if (reg_wr && reg_addr == A_CPUE) st_d.cpu_en = reg_wdata[NUM_GRP-1:0];
        if (reg_wr && reg_addr == A_MASK) st_d.gmask  = reg_wdata[0];
        if (!rst_n) begin
            st_d       = '0;
            st_d.gmask = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // read path
    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (reg_addr == AW'(g))           reg_rdata[GRP_W-1:0] = grp_flag[g];
            if (reg_addr == AW'(EN_BASE + g)) reg_rdata[GRP_W-1:0] = grp_en[g];
        end
        if (reg_addr == A_ACK)  reg_rdata[NUM_GRP-1:0] = st_q.ack;
        if (reg_addr == A_CPUF) reg_rdata[NUM_GRP-1:0] = st_q.cpu_flag;
        if (reg_addr == A_CPUE) reg_rdata[NUM_GRP-1:0] = st_q.cpu_en;
        if (reg_addr == A_MASK) reg_rdata[0]           = st_q.gmask;
    end
endmodule

// File: rtl/irqx_chk.sv
module irqx_chk #(
    parameter int unsigned G  = 12,
    parameter int unsigned GW = 4,
    parameter int unsigned AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_irq,
    input logic [GW-1:0] vec_grp,
    input logic          cpu_take,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [G-1:0]  cpu_flag,
    input logic [G-1:0]  cpu_en,
    input logic [G-1:0]  ack
);
    logic         cpuf_wr;
    logic [G-1:0] live;
    assign cpuf_wr = reg_wr && (reg_addr == AW'(2 * G + 1));
    assign live    = cpu_flag & cpu_en;

    // R6: a raised request always points at a pending, enabled line
    assert_vec_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((32'(vec_grp) < G) && (((live >> vec_grp) & G'(1)) != '0)));

    // R7: taking a forwarded interrupt drops its line flag at the next edge
    assert_take_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_take && cpu_irq && !cpuf_wr && (((ack >> vec_grp) & G'(1)) != '0))
        |=> (((cpu_flag >> $past(vec_grp)) & G'(1)) == '0));

    // R11: a take while idle never drops a line flag
    assert_idle_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_take && !cpu_irq) |=> (($past(cpu_flag) & ~cpu_flag) == '0));

    for (genvar g = 0; g < G; g++) begin : g_line
        // R3: an acknowledged group cannot raise its line by forwarding
        assert_ack_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ack[g]) && !$past(cpuf_wr)) |-> !$rose(cpu_flag[g]));
        // R3: every hardware forward leaves the group acknowledged
        assert_fwd_sets_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(cpu_flag[g]) && !$past(cpuf_wr)) |-> ack[g]);
    end
endmodule

bind irq_expander irqx_chk #(.G(NUM_GRP), .GW(GW), .AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_irq  (cpu_irq),
    .vec_grp  (vec_grp),
    .cpu_take (cpu_take),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .cpu_flag (st_q.cpu_flag),
    .cpu_en   (st_q.cpu_en),
    .ack      (st_q.ack)
);

// File: tb/irq_expander_tb.sv
`timescale 1ns/1ps
module irq_expander_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [11:0] reg_wdata = '0;
    logic [11:0] reg_rdata;
    logic        cpu_irq;
    logic [3:0]  vec_grp;
    logic [2:0]  vec_idx;
    logic        cpu_take = 1'b0;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_expander dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_irq(cpu_irq), .vec_grp(vec_grp), .vec_idx(vec_idx), .cpu_take(cpu_take)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [11:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(string tag, logic [4:0] a, logic [11:0] exp);
        reg_addr = a;
        #1;
        check(tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic pulse(logic [95:0] bits);
        @(negedge clk);
        irq_in = bits;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic take();
        @(negedge clk);
        cpu_take = 1'b1;
        @(negedge clk);
        cpu_take = 1'b0;
    endtask

    task automatic vec_chk(string tag, logic [3:0] g, logic [2:0] i);
        #1;
        check({tag, " irq"}, 32'(cpu_irq), 32'd1);
        check({tag, " grp"}, 32'(vec_grp), 32'(g));
        check({tag, " idx"}, 32'(vec_idx), 32'(i));
    endtask

    task automatic quiet_chk(string tag);
        #1;
        check(tag, 32'(cpu_irq), 32'd0);
    endtask

    task automatic t_reset();
        rd_chk("R10 mask after reset", 5'd27, 12'h001);
        rd_chk("R10 line flags after reset", 5'd25, 12'h000);
        rd_chk("R10 line enables after reset", 5'd26, 12'h000);
        rd_chk("R10 ack after reset", 5'd24, 12'h000);
        rd_chk("R10 group flag after reset", 5'd0, 12'h000);
        quiet_chk("R5 irq low after reset");
    endtask

    task automatic t_basic();
        wr(5'd26, 12'hFFF);
        wr(5'd27, 12'h000);
        pulse(96'd1 << 29);
        step(1);
        quiet_chk("R2 disabled input raises nothing");
        rd_chk("R2 flag latched while disabled", 5'd3, 12'h020);
        wr(5'd15, 12'h020);
        step(1);
        vec_chk("R1 R3 vector 3/5", 4'd3, 3'd5);
        rd_chk("R3 ack set by forward", 5'd24, 12'h008);
        take();
        quiet_chk("R7 irq drops after take");
        rd_chk("R7 group flag cleared", 5'd3, 12'h000);
        rd_chk("R7 line flag cleared", 5'd25, 12'h000);
        rd_chk("R3 ack kept after take", 5'd24, 12'h008);
    endtask

    task automatic t_ack_block();
        pulse(96'd1 << 29);
        step(2);
        quiet_chk("R3 acked group blocked");
        rd_chk("R3 blocked flag pending", 5'd3, 12'h020);
        rd_chk("R3 blocked line flag clear", 5'd25, 12'h000);
        wr(5'd24, 12'h008);
        step(1);
        vec_chk("R4 release forwards", 4'd3, 3'd5);
        take();
        wr(5'd24, 12'h008);
        rd_chk("R4 ack cleared", 5'd24, 12'h000);
    endtask

    task automatic t_priority();
        wr(5'd14, 12'h00C);
        wr(5'd19, 12'h0FF);
        pulse((96'd1 << 18) | (96'd1 << 19) | (96'd1 << 57));
        step(1);
        vec_chk("R6 lowest line lowest index", 4'd2, 3'd2);
        rd_chk("R3 two lines pending", 5'd25, 12'h084);
        take();
        vec_chk("R6 next line after take", 4'd7, 3'd1);
        rd_chk("R7 only winner bit cleared", 5'd2, 12'h008);
        take();
        quiet_chk("R7 all lines drained");
        wr(5'd24, 12'h004);
        rd_chk("R4 other ack bit kept", 5'd24, 12'h080);
        step(1);
        vec_chk("R6 remaining input forwards", 4'd2, 3'd3);
        take();
        wr(5'd24, 12'h084);
        rd_chk("R4 acks all clear", 5'd24, 12'h000);
    endtask

    task automatic t_mask_soft();
        wr(5'd27, 12'h001);
        wr(5'd12, 12'h001);
        wr(5'd0, 12'h001);
        step(1);
        quiet_chk("R5 mask holds irq low");
        rd_chk("R9 line flag visible under mask", 5'd25, 12'h001);
        wr(5'd27, 12'h000);
        vec_chk("R8 software interrupt delivered", 4'd0, 3'd0);
        take();
        wr(5'd24, 12'h001);
        quiet_chk("R7 software interrupt taken");
    endtask

    task automatic t_race();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd5; reg_wdata = 12'h001;
        irq_in = 96'd1 << 46;
        @(negedge clk);
        reg_wr = 1'b0; irq_in = '0;
        rd_chk("R8 same-cycle input kept", 5'd5, 12'h041);
        wr(5'd5, 12'h000);
        rd_chk("R8 zero write leaves flags", 5'd5, 12'h041);
        take();
        rd_chk("R11 idle take keeps group flags", 5'd5, 12'h041);
        rd_chk("R11 idle take keeps line flags", 5'd25, 12'h000);
    endtask

    task automatic t_line_enable();
        wr(5'd26, 12'hDFF);
        wr(5'd21, 12'h001);
        pulse(96'd1 << 72);
        step(1);
        rd_chk("R9 line flag set while line disabled", 5'd25, 12'h200);
        quiet_chk("R9 disabled line quiet");
        wr(5'd26, 12'hFFF);
        vec_chk("R1 R9 line enabled vector 9/0", 4'd9, 3'd0);
        take();
        wr(5'd24, 12'h200);
        quiet_chk("R7 line 9 taken");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_basic();
        t_ack_block();
        t_priority();
        t_mask_soft();
        t_race();
        t_line_enable();
        step(2);
        finish_run();
    end

    initial begin
        #1000000;
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule